// File: doc/BRIEF.md
# Linear Capture and Readout Address Sequencer

This block produces the request stream for a memory buffer that is used in two phases. First a capture phase fills the buffer. It issues only write requests, one per burst, at whatever rate the downstream command engine accepts them. Later a readout phase drains the buffer. It issues only read requests and stops after the number of bursts that the capture phase stored. In both phases the linear burst index starts at zero and rises by exactly one burst per accepted request. Requests are therefore never split, never masked and always aligned to a whole burst.

The linear index is cut into three fields. The column sits in the low bits and is scaled to word units, with its burst-offset bits held at zero. The bank sits above the column, and the row sits above the bank. A flag on each request tells the command engine when that request moves into a bank/row pair that differs from the previous request's, so that the engine knows an activation is needed. A phase ends when the buffer is full, when the stored count has been read back, or when an abort is requested. The end of a phase is reported with a one-cycle completion pulse.

Top module: `burst_addr_sequencer`

## Requirements
- R1: During and after a synchronous reset, req_valid, busy and done are 0 and stored_count is 0.
- R2: A cap_start pulse in the idle state begins a capture phase. From the next cycle on, req_valid is 1 and req_write is 1 for every request of that phase.
- R3: An rd_start pulse in the idle state, with a nonzero stored_count, begins a readout phase in which every request has req_write 0.
- R4: The first request of each phase carries linear index 0, and each accepted request (req_valid and req_ready both 1 at a clock edge) advances the index by one. For index i and C = 2^(COL_W-BURST_LOG2) bursts per row: req_col = (i mod C) * 2^BURST_LOG2, so the low BURST_LOG2 bits of req_col are always 0. req_bank = (i / C) mod 2^BANK_W, and req_row = i / (C * 2^BANK_W).
- R5: While req_valid is 1 and req_ready is 0, the request (valid, type and all address fields) holds unchanged into the next cycle.
- R6: Capture ends after the write at the last index of the buffer (2^(COL_W-BURST_LOG2+BANK_W+ROW_W) bursts) is accepted. From the next cycle req_valid is 0, done is 1 for exactly one cycle, and stored_count equals the full capacity.
- R7: abort_req during a phase ends it at that clock edge, and done pulses for one cycle. A request accepted at the same edge still counts, so after a capture stored_count equals the number of writes accepted.
- R8: Readout issues exactly stored_count reads and then ends with a one-cycle done pulse. With stored_count 0, rd_start causes a done pulse in the next cycle and no request.
- R9: req_bank_change is 1 exactly on the first request of a phase and on each request whose bank/row pair differs from that of the previous request.
- R10: cap_start and rd_start are ignored while busy. When both arrive together in the idle state, capture wins. abort_req in the idle state changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_start | input | 1 | Begin a capture phase |
| rd_start | input | 1 | Begin a readout phase |
| abort_req | input | 1 | End the current phase at once |
| req_ready | input | 1 | Command engine accepts the current request |
| req_valid | output | 1 | A request is offered |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_col | output | COL_W | Column address in words, burst aligned |
| req_bank | output | BANK_W | Bank address |
| req_row | output | ROW_W | Row address |
| req_bank_change | output | 1 | Request enters a new bank/row pair |
| stored_count | output | COL_W-BURST_LOG2+BANK_W+ROW_W+1 | Bursts written by the latest capture |
| done | output | 1 | One-cycle pulse at the end of a phase |
| busy | output | 1 | A phase is in progress |

## Verification
All outputs are registered state. A start pulse shows up as req_valid one cycle later. An accepting edge advances the address fields, the bank-change flag and stored_count in the cycle that follows. The done pulse appears in the first cycle after the ending edge, which is the same cycle in which req_valid falls. The bench drives its inputs and samples the outputs at the falling clock edge. It keeps its own accepted-request count, which it updates only at edges where it saw valid and ready together, and it checks every offered request against the field mapping for that count. It checks done and stored_count in the first cycle in which valid is low.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAP  = 2'd1,
    PH_RD   = 2'd2
  } phase_e;
endpackage

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
  import lseq_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_start,
  input  logic             rd_start,
  input  logic             abort_req,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             req_write,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W:0]   stored_q,
  output logic             done_q,
  output logic             busy
);
  localparam logic [IDX_W:0] CAP_CNT = {1'b1, {IDX_W{1'b0}}};
  localparam logic [IDX_W:0] CAP_LAST = CAP_CNT - 1'b1;

  phase_e ph_q;
  logic   hs;
  logic   last_cap;
  logic   last_rd;

  assign req_valid = (ph_q != PH_IDLE);
  assign req_write = (ph_q == PH_CAP);
  assign busy      = req_valid;
  assign hs        = req_valid & req_ready;
  assign last_cap  = ({1'b0, idx_q} == CAP_LAST);
  assign last_rd   = (({1'b0, idx_q} + 1'b1) == stored_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      idx_q    <= '0;
      stored_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (cap_start) begin
            ph_q     <= PH_CAP;
            idx_q    <= '0;
            stored_q <= '0;
          end else if (rd_start) begin
            idx_q <= '0;
            if (stored_q == '0) done_q <= 1'b1;
            else                ph_q   <= PH_RD;
          end
        end
        PH_CAP: begin
          if (hs) begin
            stored_q <= stored_q + 1'b1;
            idx_q    <= idx_q + 1'b1;
          end
          if ((hs && last_cap) || abort_req) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        PH_RD: begin
          if (hs) idx_q <= idx_q + 1'b1;
          if ((hs && last_rd) || abort_req) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R2
  one_cmd_type_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid)) |-> (req_write == $past(req_write)));

  // R5
  hold_request_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !abort_req) |=>
      (req_valid && $stable(idx_q) && $stable(req_write)));

  // R4
  index_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hs && !abort_req && !last_cap && !(!req_write && last_rd)) |=>
      (idx_q == $past(idx_q) + 1'b1));

  // R6
  no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
    stored_q <= CAP_CNT);

  // R8
  read_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |-> ({1'b0, idx_q} < stored_q));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !req_valid);
endmodule

// File: rtl/lseq_map.sv
module lseq_map #(
  parameter int COL_W      = 10,
  parameter int BURST_LOG2 = 3,
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 16
) (
  input  logic [COL_W-BURST_LOG2+BANK_W+ROW_W-1:0] idx,
  output logic [COL_W-1:0]                          col,
  output logic [BANK_W-1:0]                         bank,
  output logic [ROW_W-1:0]                          row,
  output logic                                      bank_change
);
  localparam int CB = COL_W - BURST_LOG2;

  generate
    if (BURST_LOG2 > 0) begin : g_scaled
      assign col = {idx[CB-1:0], {BURST_LOG2{1'b0}}};
    end else begin : g_plain
      assign col = idx[CB-1:0];
    end
  endgenerate

  assign bank        = idx[CB +: BANK_W];
  assign row         = idx[CB+BANK_W +: ROW_W];
  // Steps are one burst, so the bank/row pair changes exactly when the column wraps.
  assign bank_change = (idx[CB-1:0] == '0);
endmodule

// File: rtl/burst_addr_sequencer.sv
module burst_addr_sequencer #(
  parameter int COL_W      = 10,
  parameter int BURST_LOG2 = 3,
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 16,
  localparam int IDX_W     = COL_W - BURST_LOG2 + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_start,
  input  logic              rd_start,
  input  logic              abort_req,
  input  logic              req_ready,
  output logic              req_valid,
  output logic              req_write,
  output logic [COL_W-1:0]  req_col,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic              req_bank_change,
  output logic [IDX_W:0]    stored_count,
  output logic              done,
  output logic              busy
);
  logic [IDX_W-1:0] idx;

  lseq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cap_start (cap_start),
    .rd_start  (rd_start),
    .abort_req (abort_req),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_write (req_write),
    .idx_q     (idx),
    .stored_q  (stored_count),
    .done_q    (done),
    .busy      (busy)
  );

  lseq_map #(
    .COL_W      (COL_W),
    .BURST_LOG2 (BURST_LOG2),
    .BANK_W     (BANK_W),
    .ROW_W      (ROW_W)
  ) u_map (
    .idx         (idx),
    .col         (req_col),
    .bank        (req_bank),
    .row         (req_row),
    .bank_change (req_bank_change)
  );

  // R4
  col_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_col[0] == 1'b0 || BURST_LOG2 == 0));

  // R9
  first_req_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !$past(req_valid)) |-> req_bank_change);
endmodule

// File: tb/tb_burst_addr_sequencer.sv
module tb_burst_addr_sequencer;
  localparam int COL_W = 5, BL = 3, BANK_W = 1, ROW_W = 2;
  localparam int CPB = 1 << (COL_W - BL);
  localparam int BANKS = 1 << BANK_W;
  localparam int CAPN = CPB * BANKS * (1 << ROW_W);
  localparam int IDX_W = COL_W - BL + BANK_W + ROW_W;

  typedef struct packed {
    logic [7:0] abort_at;
    logic [3:0] stall;
    logic [7:0] exp_cnt;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'hFF, 4'd0, 8'd32},
    '{8'hFF, 4'd3, 8'd32},
    '{8'd5,  4'd0, 8'd6},
    '{8'd9,  4'd2, 8'd9},
    '{8'd0,  4'd3, 8'd0}
  };

  logic clk = 0, rst = 1;
  logic cap_start = 0, rd_start = 0, abort_req = 0, req_ready = 0;
  logic req_valid, req_write, req_bank_change, done, busy;
  logic [COL_W-1:0] req_col;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0] req_row;
  logic [IDX_W:0] stored_count;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  burst_addr_sequencer #(.COL_W(COL_W), .BURST_LOG2(BL), .BANK_W(BANK_W), .ROW_W(ROW_W)) dut (
    .clk(clk), .rst(rst), .cap_start(cap_start), .rd_start(rd_start),
    .abort_req(abort_req), .req_ready(req_ready), .req_valid(req_valid),
    .req_write(req_write), .req_col(req_col), .req_bank(req_bank),
    .req_row(req_row), .req_bank_change(req_bank_change),
    .stored_count(stored_count), .done(done), .busy(busy));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_fields(int i, logic wr);
    chk("R2/R3 type", int'(req_write), int'(wr));
    chk("R4 col", int'(req_col), (i % CPB) << BL);
    chk("R4 bank", int'(req_bank), (i / CPB) % BANKS);
    chk("R4 row", int'(req_row), i / (CPB * BANKS));
    chk("R9 bank change", int'(req_bank_change), int'((i % CPB) == 0));
  endtask

  // Runs one phase; returns number of accepted requests.
  task automatic run_phase(logic wr, int abort_at, int stall, output int acc);
    int cyc = 0;
    acc = 0;
    if (wr) cap_start = 1; else rd_start = 1;
    @(negedge clk);
    cap_start = 0; rd_start = 0;
    while (req_valid && cyc < 200) begin
      chk_fields(acc, wr);
      abort_req = 0;
      req_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (acc == abort_at) begin
        abort_req = 1;
        req_ready = (stall == 0);
      end
      if (req_ready) acc++;
      cyc++;
      @(negedge clk);
    end
    abort_req = 0; req_ready = 0;
    chk("R6/R7/R8 done pulse", int'(done), 1);
    chk("R6/R7/R8 valid low", int'(req_valid), 0);
    @(negedge clk);
    chk("R6/R7/R8 done single", int'(done), 0);
  endtask

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(req_valid), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 count", int'(stored_count), 0);
    rst = 0;
    @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      run_phase(1'b1, int'(VECS[v].abort_at), int'(VECS[v].stall), acc);
      chk("R6/R7 accepted", acc, int'(VECS[v].exp_cnt));
      chk("R6/R7 stored_count", int'(stored_count), int'(VECS[v].exp_cnt));
      run_phase(1'b0, 255, int'(VECS[v].stall), acc);
      chk("R8 reads issued", acc, int'(VECS[v].exp_cnt));
    end

    // R10: starts ignored while busy; R5 hold while stalled
    cap_start = 1; @(negedge clk); cap_start = 0;
    chk("R2 capture valid", int'(req_valid), 1);
    rd_start = 1; cap_start = 1; @(negedge clk); rd_start = 0; cap_start = 0;
    chk("R10 still write", int'(req_write), 1);
    chk("R5 held col", int'(req_col), 0);
    req_ready = 1; @(negedge clk); req_ready = 0;
    chk("R4 advanced", int'(req_col), 1 << BL);
    cap_start = 1; @(negedge clk); cap_start = 0;
    chk("R10 restart ignored", int'(req_col), 1 << BL);
    chk("R10 count kept", int'(stored_count), 1);
    abort_req = 1; @(negedge clk); abort_req = 0;
    chk("R7 abort done", int'(done), 1);
    chk("R7 abort count", int'(stored_count), 1);

    // R10: abort in idle has no effect
    abort_req = 1; @(negedge clk); abort_req = 0;
    chk("R10 idle abort done", int'(done), 0);
    chk("R10 idle abort count", int'(stored_count), 1);
    chk("R10 idle abort valid", int'(req_valid), 0);

    // R10: both starts in idle, capture wins
    cap_start = 1; rd_start = 1; @(negedge clk); cap_start = 0; rd_start = 0;
    chk("R10 capture wins", int'(req_write), 1);
    chk("R10 count cleared", int'(stored_count), 0);
    abort_req = 1; @(negedge clk); abort_req = 0;
    chk("R7 abort no accept", int'(stored_count), 0);

    // R8 empty readout
    run_phase(1'b0, 255, 0, acc);
    chk("R8 empty reads", acc, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule